// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

This block turns a 17-bit word address in a virtual program space of 128K words into an 18-bit physical word address in a memory of up to 256K words. The space is cut into 512-word pages. The nine low address bits are the word offset and are not changed. The upper eight bits select one of 256 page entries. Each entry supplies a 9-bit physical page number. Any virtual page may point at any physical page. A program that lies in scattered pieces of memory therefore still appears as one contiguous block.

Each page entry also holds a 2-bit protection code. Every access made in the unprivileged (slave) mode is checked against the code of its page, and an access that is not allowed raises a one-cycle violation pulse. Privileged (master) accesses are never checked. Software fills the table through an indexed write port, which loads a page number and a code together. The translation is combinational from the address. The violation flag is registered.

Top module: `page_map_xlate`

## Requirements
- R1: After reset `viol` is 0, and every page entry maps virtual page n to physical page n with protection code 00. The physical address therefore equals the zero-extended virtual address.
- R2: `phys_addr[8:0]` always equals `acc_vaddr[8:0]` in the same cycle.
- R3: `phys_addr[17:9]` equals the page number stored for page `acc_vaddr[16:9]`, combinationally in the same cycle.
- R4: Entries are independent. Any virtual page can be mapped to any physical page, including several virtual pages mapped to one physical page, and writing one entry leaves the other entries unchanged.
- R5: Protection code 00 allows every access kind. `acc_kind` uses 00 for read, 01 for write, 10 for instruction fetch and 11 for reserved.
- R6: Code 01 allows read and fetch. In slave mode it rejects write and the reserved kind 11, which is checked as a write.
- R7: Code 10 allows only read. In slave mode it rejects write, fetch and kind 11.
- R8: Code 11 rejects every access kind in slave mode.
- R9: When `master_mode` is 1, no access raises `viol`, whatever the code.
- R10: `viol` is 1 in the cycle after an offending access with `acc_valid` = 1, for one cycle per offending access. Back-to-back offending accesses hold it high on consecutive cycles. Nothing raises it while `acc_valid` is 0.
- R11: A table write takes effect from the following cycle. An access in the same cycle as the write to its page uses the previous entry, for both translation and check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_vaddr | input | 17 | Virtual word address |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved (checked as write) |
| master_mode | input | 1 | 1 = privileged, protection bypassed |
| map_we | input | 1 | Table entry write strobe |
| map_idx | input | 8 | Virtual page to load |
| map_ppn | input | 9 | Physical page number to store |
| map_code | input | 2 | Protection code to store |
| phys_addr | output | 18 | Translated physical word address |
| viol | output | 1 | Registered protection violation pulse |

## Verification
A table write and an access can land on the same page in the same cycle. The bench provokes this by loading a page with a new physical page and code 11 while a slave write to that page is presented. The translated address must still show the old physical page, and the following cycle must show no violation, because the old code was 00. A second access in the next cycle must show the new page and raise the violation. Back-to-back offending accesses also check that each one yields its own pulse.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    PG_FULL = 2'b00,
    PG_RX   = 2'b01,
    PG_RO   = 2'b10,
    PG_NONE = 2'b11
  } pg_code_e;
endpackage

// File: rtl/pmap_table.sv
module pmap_table
  import pmap_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PPN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  pg_code_e         wr_code,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PPN_W-1:0] rd_ppn,
  output pg_code_e         rd_code
);
  localparam int DEPTH = 1 << IDX_W;

  logic [PPN_W-1:0] ppn_q  [DEPTH];
  pg_code_e         code_q [DEPTH];

  // Reset loads an identity map with full access
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        ppn_q[i]  <= PPN_W'(i);
        code_q[i] <= PG_FULL;
      end
    end else if (wr_en) begin
      ppn_q[wr_idx]  <= wr_ppn;
      code_q[wr_idx] <= wr_code;
    end
  end

  // Asynchronous read: the current access sees the entry before any same-cycle write
  assign rd_ppn  = ppn_q[rd_idx];
  assign rd_code = code_q[rd_idx];

  // R11
  tbl_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ppn_q[$past(wr_idx)] == $past(wr_ppn)) && (code_q[$past(wr_idx)] == $past(wr_code)));
endmodule

// File: rtl/pmap_guard.sv
module pmap_guard
  import pmap_pkg::*;
(
  input  acc_kind_e kind,
  input  pg_code_e  code,
  input  logic      master,
  output logic      deny
);
  logic allowed;

  always_comb begin
    case (code)
      PG_FULL: allowed = 1'b1;
      PG_RX:   allowed = (kind == ACC_READ) || (kind == ACC_FETCH);
      PG_RO:   allowed = (kind == ACC_READ);
      default: allowed = 1'b0;
    endcase
  end

  assign deny = !master && !allowed;
endmodule

// File: rtl/page_map_xlate.sv
module page_map_xlate
  import pmap_pkg::*;
#(
  parameter int VA_W  = 17,
  parameter int PA_W  = 18,
  parameter int OFS_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_valid,
  input  logic [VA_W-1:0]       acc_vaddr,
  input  logic [1:0]            acc_kind,
  input  logic                  master_mode,
  input  logic                  map_we,
  input  logic [VA_W-OFS_W-1:0] map_idx,
  input  logic [PA_W-OFS_W-1:0] map_ppn,
  input  logic [1:0]            map_code,
  output logic [PA_W-1:0]       phys_addr,
  output logic                  viol
);
  localparam int IDX_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;

  logic [IDX_W-1:0] vpn;
  logic [PPN_W-1:0] ppn;
  pg_code_e         code;
  logic             deny;
  logic             viol_q;

  assign vpn = acc_vaddr[VA_W-1:OFS_W];

  pmap_table #(.IDX_W(IDX_W), .PPN_W(PPN_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (map_we),
    .wr_idx  (map_idx),
    .wr_ppn  (map_ppn),
    .wr_code (pg_code_e'(map_code)),
    .rd_idx  (vpn),
    .rd_ppn  (ppn),
    .rd_code (code)
  );

  pmap_guard u_guard (
    .kind   (acc_kind_e'(acc_kind)),
    .code   (code),
    .master (master_mode),
    .deny   (deny)
  );

  assign phys_addr = {ppn, acc_vaddr[OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) viol_q <= 1'b0;
    else     viol_q <= acc_valid && deny;
  end

  assign viol = viol_q;

  // R8
  none_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !master_mode && code == PG_NONE) |=> viol);

  // R6
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !master_mode && code != PG_FULL && acc_kind[0]) |=> viol);

  // R7
  ro_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !master_mode && code == PG_RO && acc_kind == 2'b10) |=> viol);

  // R5
  full_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && code == PG_FULL) |=> !viol);

  // R9
  master_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && master_mode) |=> !viol);

  // R10
  viol_src_chk: assert property (@(posedge clk) disable iff (rst)
    viol |-> ($past(acc_valid) && !$past(master_mode)));
endmodule

// File: tb/tb_page_map_xlate.sv
module tb_page_map_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid;
  logic [16:0] acc_vaddr;
  logic [1:0]  acc_kind;
  logic        master_mode;
  logic        map_we;
  logic [7:0]  map_idx;
  logic [8:0]  map_ppn;
  logic [1:0]  map_code;
  logic [17:0] phys_addr;
  logic        viol;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [8:0] ppn_m  [256];
  logic [1:0] code_m [256];

  always #10 clk = ~clk;

  page_map_xlate dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
    .acc_kind(acc_kind), .master_mode(master_mode), .map_we(map_we),
    .map_idx(map_idx), .map_ppn(map_ppn), .map_code(map_code),
    .phys_addr(phys_addr), .viol(viol)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit permitted(input logic [1:0] code, input logic [1:0] kind, input bit mst);
    if (mst) return 1'b1;
    case (code)
      2'b00:   return 1'b1;
      2'b01:   return kind == 2'b00 || kind == 2'b10;
      2'b10:   return kind == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  task automatic load(input logic [7:0] idx, input logic [8:0] ppn, input logic [1:0] code);
    @(negedge clk);
    map_we = 1; map_idx = idx; map_ppn = ppn; map_code = code;
    @(negedge clk);
    map_we = 0;
    ppn_m[idx] = ppn; code_m[idx] = code;
  endtask

  task automatic access(input logic [16:0] va, input logic [1:0] kind, input bit mst, input string req);
    logic [17:0] ep;
    bit ev;
    @(negedge clk);
    acc_valid = 1; acc_vaddr = va; acc_kind = kind; master_mode = mst;
    ep = {ppn_m[va[16:9]], va[8:0]};
    ev = !permitted(code_m[va[16:9]], kind, mst);
    #1 chk(phys_addr == ep, req, phys_addr, ep);
    @(negedge clk);
    acc_valid = 0;
    chk(viol == ev, req, viol, ev);
  endtask

  task automatic t_reset;
    chk(viol == 0, "R1", viol, 0);
    access(17'h1ABCD, 2'b01, 0, "R1");
    access(17'h00005, 2'b10, 0, "R1");
  endtask

  task automatic t_mapping;
    load(8'h03, 9'h1F0, 2'b00);
    load(8'h04, 9'h002, 2'b00);
    load(8'h90, 9'h1F0, 2'b00);
    access({8'h03, 9'h1FF}, 2'b00, 0, "R3");
    access({8'h04, 9'h000}, 2'b00, 0, "R2");
    access({8'h90, 9'h0AA}, 2'b01, 0, "R4");
    access({8'h05, 9'h123}, 2'b00, 0, "R4");
  endtask

  task automatic t_codes;
    load(8'h10, 9'h011, 2'b00);
    load(8'h11, 9'h012, 2'b01);
    load(8'h12, 9'h013, 2'b10);
    load(8'h13, 9'h014, 2'b11);
    for (int k = 0; k < 4; k++) begin
      access({8'h10, 9'h001}, 2'(k), 0, "R5");
      access({8'h11, 9'h002}, 2'(k), 0, "R6");
      access({8'h12, 9'h003}, 2'(k), 0, "R7");
      access({8'h13, 9'h004}, 2'(k), 0, "R8");
    end
  endtask

  task automatic t_master;
    for (int k = 0; k < 4; k++) begin
      access({8'h13, 9'h010}, 2'(k), 1, "R9");
      access({8'h12, 9'h011}, 2'(k), 1, "R9");
    end
  endtask

  task automatic t_pulse;
    @(negedge clk);
    acc_valid = 1; master_mode = 0; acc_kind = 2'b01; acc_vaddr = {8'h13, 9'h0};
    @(negedge clk);
    acc_vaddr = {8'h11, 9'h5};
    chk(viol == 1, "R10", viol, 1);
    @(negedge clk);
    acc_valid = 0;
    chk(viol == 1, "R10", viol, 1);
    @(negedge clk);
    chk(viol == 0, "R10", viol, 0);
    acc_vaddr = {8'h13, 9'h0};
    @(negedge clk);
    chk(viol == 0, "R10", viol, 0);
  endtask

  task automatic t_same_cycle;
    logic [17:0] ep;
    @(negedge clk);
    map_we = 1; map_idx = 8'h20; map_ppn = 9'h155; map_code = 2'b11;
    acc_valid = 1; acc_vaddr = {8'h20, 9'h0C3}; acc_kind = 2'b01; master_mode = 0;
    ep = {ppn_m[8'h20], 9'h0C3};
    #1 chk(phys_addr == ep, "R11", phys_addr, ep);
    @(negedge clk);
    map_we = 0; acc_valid = 0;
    chk(viol == 0, "R11", viol, 0);
    ppn_m[8'h20] = 9'h155; code_m[8'h20] = 2'b11;
    access({8'h20, 9'h0C3}, 2'b01, 0, "R11");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ppn_m[i] = 9'(i);
      code_m[i] = 2'b00;
    end
    rst = 1; acc_valid = 0; acc_vaddr = '0; acc_kind = '0; master_mode = 0;
    map_we = 0; map_idx = '0; map_ppn = '0; map_code = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_mapping();
    t_codes();
    t_master();
    t_pulse();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule